// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 62 level-sensitive interrupt sources, ranks the ones that are both asserted and enabled by a programmable 3-bit priority, and raises a single interrupt line to the processor. Software reaches it over a simple register port with address, write data, write strobe, read strobe and combinational read data. Enables are changed only through separate set and clear registers, so a read-modify-write sequence is never needed. Raw and masked source levels can be read back at any time.

Vector delivery takes two reads and one write. A read of the pending-vector register returns the winning channel shifted left by two. It also copies that channel into the source-number register and marks the controller as in service. While the controller is in service, the interrupt line stays low and no new vector is offered. A read of the source-number register returns the latched channel and then zeroes it. A write of any value to the end-of-service register re-arms the controller. Channel 0 is never delivered, because a vector of 0 means that no source is pending.

Top module: `pirq_ctrl`

## Requirements
- R1: A write to the low enable-set register (word address 0x46) sets enable bit n for every 1 in write-data bit n, for channels 0 to 31. A write to the high enable-set register (0x47) does the same for channel n+32 from data bit n. Zero bits leave the enable unchanged.
- R2: A write to the low enable-clear register (0x48) or the high enable-clear register (0x49) clears the matching enables bit for bit, and zero bits leave them unchanged. The enables read back at 0x44 (channels 0 to 31) and 0x45 (channels 32 to 61, in bits 29:0).
- R3: Address 0x40 reads source levels 31:0 and 0x41 reads source levels 61:32, both regardless of enable. Address 0x42 and 0x43 read the same two halves ANDed with the enables.
- R4: Word address n (0 to 61) holds the 3-bit priority of channel n in bits 2:0, where 0 is the most urgent. The winner is the active, enabled channel with the lowest priority value. On a tie, the lower channel number wins.
- R5: Channel 0 is never selected as the winner, even when it is active and enabled.
- R6: When no service is in progress, irq_o is high exactly when a winner exists. It follows a source or enable change at the second rising edge after that change is captured.
- R7: A read of the pending-vector register (0x4A) returns the winning channel in bits 7:2, with all other bits 0. It returns 0 when there is no winner or while a service is in progress.
- R8: A pending-vector read that returns a nonzero value has three effects. It copies the channel into the source-number register (0x4B, bits 5:0), it starts a service, and it drives irq_o low from the next cycle until end of service.
- R9: A read of the source-number register returns its contents and leaves it at 0.
- R10: A write of any data to the end-of-service register (0x4C) ends the service. The same write has no effect when no service is in progress.
- R11: After reset all enables, all priorities, the service flag and the source-number register are 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| addr_i | input | 7 | Register word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (read side effects happen at the clock edge) |
| rdata_o | output | 32 | Read data, valid in the same cycle as re_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that each cycle carries at most one register access, either a read or a write, at one address. This makes the pending-vector read, the source-number read and the end-of-service write mutually exclusive. The bench drives exactly one access per task call and returns both strobes to zero between calls. Source levels change only between accesses and are then held for two cycles, so the registered winner has settled before the pending vector is read. Random source patterns and enable and priority writes are mixed with directed cases: ties, channel 0 alone, the mask-all-but-two pattern and an end-of-service write while idle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned PRIO_W = 3;
    localparam int unsigned ID_W   = 6;

    localparam logic [ADDR_W-1:0] A_RAW_LO = 7'h40;
    localparam logic [ADDR_W-1:0] A_RAW_HI = 7'h41;
    localparam logic [ADDR_W-1:0] A_ACT_LO = 7'h42;
    localparam logic [ADDR_W-1:0] A_ACT_HI = 7'h43;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 7'h44;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 7'h45;
    localparam logic [ADDR_W-1:0] A_SET_LO = 7'h46;
    localparam logic [ADDR_W-1:0] A_SET_HI = 7'h47;
    localparam logic [ADDR_W-1:0] A_CLR_LO = 7'h48;
    localparam logic [ADDR_W-1:0] A_CLR_HI = 7'h49;
    localparam logic [ADDR_W-1:0] A_PEND   = 7'h4A;
    localparam logic [ADDR_W-1:0] A_SNUM   = 7'h4B;
    localparam logic [ADDR_W-1:0] A_EOS    = 7'h4C;

    // One arbitration candidate: channel, its priority, and whether it competes
    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;
endpackage

// File: rtl/pirq_enable_bank.sv
module pirq_enable_bank
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 62
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    set_lo_i,
    input  logic                    set_hi_i,
    input  logic                    clr_lo_i,
    input  logic                    clr_hi_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [NUM_SRC-1:0]      en_o
);
    localparam int unsigned LO_W = 32;
    localparam int unsigned HI_W = NUM_SRC - LO_W;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_lo_i) st_d.lo = st_q.lo | wdata_i;
        if (clr_lo_i) st_d.lo = st_q.lo & ~wdata_i;
        if (set_hi_i) st_d.hi = st_q.hi | wdata_i[HI_W-1:0];
        if (clr_hi_i) st_d.hi = st_q.hi & ~wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o = {st_q.hi, st_q.lo};

    // R1: set strobes raise every written-one bit
    a_r1_set_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_lo_i |=> ((en_o[LO_W-1:0] & $past(wdata_i)) == $past(wdata_i)));
    // R2: clear strobes drop every written-one bit and keep the others
    a_r2_clr_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_hi_i |=> (en_o[NUM_SRC-1:LO_W] == ($past(en_o[NUM_SRC-1:LO_W]) & ~$past(wdata_i[HI_W-1:0]))));
endmodule

// File: rtl/pirq_prio_bank.sv
module pirq_prio_bank
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 62
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           idx_i,
    input  logic [PRIO_W-1:0]           wdata_i,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_o
);
    logic [PRIO_W-1:0] prio_d [NUM_SRC];
    logic [PRIO_W-1:0] prio_q [NUM_SRC];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            prio_d[i] = prio_q[i];
            if (we_i && idx_i == ADDR_W'(i)) prio_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= prio_d[i];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
        assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
endmodule

// File: rtl/pirq_arb_tree.sv
module pirq_arb_tree
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 62
) (
    input  logic [NUM_SRC-1:0]          act_i,
    input  logic [NUM_SRC*PRIO_W-1:0]   prio_i,
    output logic                        win_vld_o,
    output logic [ID_W-1:0]             win_id_o
);
    localparam int unsigned LVLS   = $clog2(NUM_SRC);
    localparam int unsigned LEAVES = 1 << LVLS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    // Heap layout: node i has children 2i+1 (lower channels) and 2i+2
    cand_t node [NODES];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k > 0 && k < NUM_SRC) begin : g_real
            assign node[LEAVES-1+k] = '{valid: act_i[k],
                                        prio:  prio_i[k*PRIO_W +: PRIO_W],
                                        id:    ID_W'(k)};
        end else begin : g_pad
            // channel 0 is reserved as the "no source" code; padding never competes
            assign node[LEAVES-1+k] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        cand_t l, r;
        assign l = node[2*n+1];
        assign r = node[2*n+2];
        // left holds lower channel numbers, so it keeps ties
        assign node[n] = (l.valid && (!r.valid || l.prio <= r.prio)) ? l : r;
    end

    assign win_vld_o = node[0].valid;
    assign win_id_o  = node[0].id;
endmodule

// File: rtl/pirq_vector_ctrl.sv
module pirq_vector_ctrl
    import pirq_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            arb_vld_i,
    input  logic [ID_W-1:0] arb_id_i,
    input  logic            pend_rd_i,
    input  logic            snum_rd_i,
    input  logic            eos_wr_i,
    output logic [ID_W-1:0] pend_vec_o,
    output logic [ID_W-1:0] snum_o,
    output logic            irq_o
);
    typedef struct packed {
        logic            win_vld;
        logic [ID_W-1:0] win_id;
        logic            svc;
        logic [ID_W-1:0] snum;
    } vec_state_t;

    vec_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.win_vld = arb_vld_i;
        st_d.win_id  = arb_id_i;
        if (pend_rd_i && st_q.win_vld && !st_q.svc) begin
            st_d.svc  = 1'b1;
            st_d.snum = st_q.win_id;
        end
        if (snum_rd_i) st_d.snum = '0;
        if (eos_wr_i)  st_d.svc  = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o      = st_q.win_vld && !st_q.svc;
    assign pend_vec_o = irq_o ? st_q.win_id : '0;
    assign snum_o     = st_q.snum;

    // R8: an offered vector read is latched and service begins
    a_r8_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_rd_i && irq_o) |=> (st_q.svc && !irq_o && snum_o == $past(pend_vec_o)));
    // R8: service holds until end of service
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.svc && !eos_wr_i) |=> st_q.svc);
    // R9: source number reads back as zero afterwards
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snum_rd_i |=> (snum_o == '0));
    // R10: end of service always leaves the idle state
    a_r10_eos: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eos_wr_i |=> !st_q.svc);
    // R5: the reserved code never becomes a presented winner
    a_r5_no_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.win_vld |-> (st_q.win_id != '0));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 62
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                we_i,
    input  logic                re_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                irq_o
);
    localparam int unsigned LO_W = 32;
    localparam int unsigned HI_W = NUM_SRC - LO_W;

    logic [NUM_SRC-1:0]        en;
    logic [NUM_SRC-1:0]        act;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      arb_vld;
    logic [ID_W-1:0]           arb_id;
    logic [ID_W-1:0]           pend_vec;
    logic [ID_W-1:0]           snum;
    logic                      prio_we;
    logic                      pend_rd, snum_rd, eos_wr;

    assign act     = src_i & en;
    assign prio_we = we_i && (addr_i < ADDR_W'(NUM_SRC));
    assign pend_rd = re_i && addr_i == A_PEND;
    assign snum_rd = re_i && addr_i == A_SNUM;
    assign eos_wr  = we_i && addr_i == A_EOS;

    pirq_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_lo_i (we_i && addr_i == A_SET_LO),
        .set_hi_i (we_i && addr_i == A_SET_HI),
        .clr_lo_i (we_i && addr_i == A_CLR_LO),
        .clr_hi_i (we_i && addr_i == A_CLR_HI),
        .wdata_i  (wdata_i),
        .en_o     (en)
    );

    pirq_prio_bank #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (prio_we),
        .idx_i   (addr_i),
        .wdata_i (wdata_i[PRIO_W-1:0]),
        .prio_o  (prio_flat)
    );

    pirq_arb_tree #(.NUM_SRC(NUM_SRC)) u_arb (
        .act_i     (act),
        .prio_i    (prio_flat),
        .win_vld_o (arb_vld),
        .win_id_o  (arb_id)
    );

    pirq_vector_ctrl u_vec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arb_vld_i  (arb_vld),
        .arb_id_i   (arb_id),
        .pend_rd_i  (pend_rd),
        .snum_rd_i  (snum_rd),
        .eos_wr_i   (eos_wr),
        .pend_vec_o (pend_vec),
        .snum_o     (snum),
        .irq_o      (irq_o)
    );

    // Read mux: side-effect-free decode, side effects live in u_vec
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_RAW_LO: rdata_o = src_i[LO_W-1:0];
            A_RAW_HI: rdata_o = DATA_W'(src_i[NUM_SRC-1:LO_W]);
            A_ACT_LO: rdata_o = act[LO_W-1:0];
            A_ACT_HI: rdata_o = DATA_W'(act[NUM_SRC-1:LO_W]);
            A_EN_LO:  rdata_o = en[LO_W-1:0];
            A_EN_HI:  rdata_o = DATA_W'(en[NUM_SRC-1:LO_W]);
            A_PEND:   rdata_o = DATA_W'({pend_vec, 2'b00});
            A_SNUM:   rdata_o = DATA_W'(snum);
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (addr_i == ADDR_W'(i)) rdata_o = DATA_W'(prio_flat[i*PRIO_W +: PRIO_W]);
                end
            end
        endcase
    end

    // R4: the combinational winner is always an active, enabled channel
    a_r4_winner_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arb_vld |-> (act[arb_id] && arb_id < ID_W'(NUM_SRC)));
    // R6: nothing active means no request one cycle later
    a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act[NUM_SRC-1:1] == '0) |=> !irq_o);
    // R7: the vector reads as zero whenever the request line is low
    a_r7_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (pend_vec == '0));
    initial a_r11_width: assert (HI_W > 0 && HI_W <= LO_W);
endmodule

// File: tb/sim_pirq_ctrl.sv
module sim_pirq_ctrl;
    localparam int NSRC = 62;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src = '0;
    logic [6:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic             we = 1'b0;
    logic             re = 1'b0;
    logic [31:0]      rdata;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NSRC-1:0] m_en = '0;
    logic [2:0]      m_prio [NSRC];
    logic            m_svc = 1'b0;
    logic [5:0]      m_snum = '0;

    always #2 clk = ~clk;

    pirq_ctrl #(.NUM_SRC(NSRC)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
        .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a == 7'h46) m_en[31:0]  = m_en[31:0] | d;
        if (a == 7'h47) m_en[61:32] = m_en[61:32] | d[29:0];
        if (a == 7'h48) m_en[31:0]  = m_en[31:0] & ~d;
        if (a == 7'h49) m_en[61:32] = m_en[61:32] & ~d[29:0];
        if (a < 7'd62) m_prio[a] = d[2:0];
        if (a == 7'h4C) m_svc = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // expected winner: {valid, id}
    function automatic logic [6:0] model_win();
        logic [6:0] w = '0;
        int best = 8;
        for (int i = 1; i < NSRC; i++) begin
            if (src[i] && m_en[i] && int'(m_prio[i]) < best) begin
                best = int'(m_prio[i]);
                w = {1'b1, 6'(i)};
            end
        end
        return w;
    endfunction

    // read pending vector, check, and update model
    task automatic take_vector(input string req);
        logic [6:0] w;
        logic [31:0] d, exp;
        w = model_win();
        exp = (!m_svc && w[6]) ? {24'd0, w[5:0], 2'b00} : 32'd0;
        rd(7'h4A, d);
        check(d == exp, req, d, exp);
        if (exp != 0) begin
            m_svc = 1'b1;
            m_snum = w[5:0];
        end
    endtask

    task automatic check_irq(input string req);
        logic [6:0] w;
        w = model_win();
        check(irq == (w[6] && !m_svc), req, {31'd0, irq}, {31'd0, w[6] && !m_svc});
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSRC; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(irq == 1'b0, "R11 irq", {31'd0, irq}, 0);
        rd(7'h44, d); check(d == 0, "R11 en lo", d, 0);
        rd(7'h45, d); check(d == 0, "R11 en hi", d, 0);
        rd(7'h4B, d); check(d == 0, "R11 snum", d, 0);
        rd(7'd17, d); check(d == 0, "R11 prio", d, 0);

        // R1 set and R2 clear, then mask all but the two lowest channels
        wr(7'h46, 32'hFFFF_FFFF);
        wr(7'h47, 32'hFFFF_FFFF);
        rd(7'h45, d); check(d == 32'h3FFF_FFFF, "R1 hi set", d, 32'h3FFF_FFFF);
        wr(7'h48, 32'hFFFF_FFFC);
        wr(7'h49, 32'hFFFF_FFFF);
        rd(7'h44, d); check(d == 32'h3, "R2 lo clr", d, 32'h3);
        rd(7'h45, d); check(d == 0, "R2 hi clr", d, 0);
        wr(7'h46, 32'h0000_0000);
        rd(7'h44, d); check(d == 32'h3, "R1 zero bits keep", d, 32'h3);

        // R5: channel 0 alone never wins
        src = '0; src[0] = 1'b1;
        settle();
        check(irq == 1'b0, "R5 irq", {31'd0, irq}, 0);
        take_vector("R5 pend");

        // R3 status reads
        src = 62'h2AAA_0000_8000_0101;
        wr(7'h47, 32'h0000_0F00);
        rd(7'h40, d); check(d == src[31:0], "R3 raw lo", d, src[31:0]);
        rd(7'h41, d); check(d == {2'b0, src[61:32]}, "R3 raw hi", d, {2'b0, src[61:32]});
        rd(7'h42, d); check(d == (src[31:0] & m_en[31:0]), "R3 act lo", d, src[31:0] & m_en[31:0]);
        rd(7'h43, d); check(d == {2'b0, src[61:32] & m_en[61:32]}, "R3 act hi", d, {2'b0, src[61:32] & m_en[61:32]});

        // R4 tie goes to lower channel; priority beats channel order
        wr(7'h48, 32'hFFFF_FFFF); wr(7'h49, 32'hFFFF_FFFF);
        wr(7'd10, 32'd2); wr(7'd40, 32'd2); wr(7'd50, 32'd0); wr(7'd3, 32'd1);
        wr(7'h46, 32'h0000_0408); wr(7'h47, 32'h0004_0100);
        src = '0; src[10] = 1'b1; src[40] = 1'b1;
        settle();
        check_irq("R6 irq raised");
        take_vector("R4 tie lower channel");
        check(irq == 1'b0, "R8 irq low in service", {31'd0, irq}, 0);
        take_vector("R7 zero while in service");
        rd(7'h4B, d); check(d == 32'd10, "R8 snum", d, 32'd10);
        rd(7'h4B, d); check(d == 0, "R9 snum cleared", d, 0);
        wr(7'h4C, 32'h0);
        src[3] = 1'b1; src[50] = 1'b1;
        settle();
        take_vector("R4 priority wins");
        rd(7'h4B, d); check(d == 32'd50, "R8 snum hi", d, 32'd50);
        wr(7'h4C, 32'hDEAD_BEEF);
        settle();
        check_irq("R10 eos rearms");
        // R10: end of service while idle leaves the request pending
        wr(7'h4C, 32'h1);
        settle();
        check_irq("R10 eos idle no effect");
        take_vector("R10 vector after idle eos");
        rd(7'h4B, d); check(d == 32'd50, "R10 snum", d, 32'd50);
        wr(7'h4C, 32'h0);

        // random phase
        for (int it = 0; it < 300; it++) begin
            for (int k = 0; k < int'($urandom_range(3, 1)); k++) begin
                case ($urandom_range(4, 0))
                    0: wr(7'h46, $urandom() & $urandom());
                    1: wr(7'h47, $urandom());
                    2: wr(7'h48, $urandom() & $urandom());
                    3: wr(7'h49, $urandom() & $urandom());
                    default: wr(7'($urandom_range(61, 0)), $urandom());
                endcase
            end
            if ($urandom_range(7, 0) == 0) src = '0;
            else src = {30'($urandom() & $urandom()), $urandom() & $urandom() & $urandom()};
            settle();
            check_irq("R6 random irq");
            take_vector("R4 random vector");
            if (m_svc) begin
                check(irq == 1'b0, "R8 random irq low", {31'd0, irq}, 0);
                take_vector("R7 random in service");
                rd(7'h4B, d); check(d == {26'd0, m_snum}, "R8 random snum", d, {26'd0, m_snum});
                rd(7'h4B, d); check(d == 0, "R9 random clear", d, 0);
                wr(7'h4C, $urandom());
            end else begin
                rd(7'h4B, d); check(d == 0, "R9 random idle snum", d, 0);
            end
            if ($urandom_range(3, 0) == 0) begin
                logic [31:0] e;
                rd(7'h44, d); e = m_en[31:0];
                check(d == e, "R1 R2 random en lo", d, e);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule